// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a processor from one operating point to another without ever running the clock faster than the supply voltage allows. A speed governor hands it a target speed level through a request pulse. The sequencer then drives two codes: a voltage-level code to an external regulator and a clock-divider code to the clock generator. It changes them in an order that depends on the direction of the move. When slowing down, the clock is slowed before the voltage drops. When speeding up, the voltage is raised first, the block waits for it to settle, and only then is the clock sped up.

Every voltage change is followed by a settling wait. A counter is loaded from a programmable settle value and advances only on an external timer tick. When the build option for it is enabled, the block also waits for a regulator-ready input. A request that arrives during a transition is held and served after the current one finishes; the latest such request replaces any earlier waiting one. The acknowledge pulse is issued only when the sequencer returns to rest.

Speed levels are codes from 0 to 2^LEVEL_W-1. The top code is full speed. Voltage scales linearly with speed, so the voltage code equals the level. The divider code is the distance from full speed. A floor parameter gives the lowest permitted level and stands for the configured minimum supply.

Top module: `vfs_sequencer`

## Requirements
- R1: After reset, volt_code is the full-speed level (7 with default parameters), clk_div is 0, and req_ack is low.
- R2: For a request below the current level, clk_div changes first (to 7 minus the target). volt_code changes to the target one cycle later. req_ack pulses 5+N cycles after the clock edge that samples the request, where N is settle_cycles.
- R3: For a request above the current level, volt_code changes first (to the target). clk_div changes N+2 cycles later. req_ack pulses 5+N cycles after the sampling edge.
- R4: The settling counter is loaded from settle_cycles at each voltage change and counts down only in cycles where tick is high. While tick stays low, the transition does not complete.
- R5: With the ready option enabled (default), the step that follows a voltage change waits while reg_ready is low. On a rising move, that step is the clock change; on a falling move, it is completion.
- R6: A request equal to the current level leaves both codes unchanged. Its req_ack pulses 2 cycles after the sampling edge.
- R7: A request that arrives during a transition is latched and served after the current transition's acknowledge. If several arrive, only the last one is served.
- R8: A request below MIN_LEVEL (2 by default) is treated as MIN_LEVEL.
- R9: At all times volt_code is at least 7 minus clk_div, so the supply always covers the clock speed.
- R10: req_ack is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe from the governor |
| req_level | input | LEVEL_W | Requested speed level (top code = full speed) |
| settle_cycles | input | SETTLE_W | Settling count loaded after each voltage change |
| reg_ready | input | 1 | Regulator output in range |
| tick | input | 1 | Timer strobe that advances the settling count |
| req_ack | output | 1 | Pulse on return to rest after serving a request |
| volt_code | output | LEVEL_W | Voltage-level code to the regulator |
| clk_div | output | LEVEL_W | Clock-divider code to the clock generator |

## Verification
The bench samples on the falling edge and counts how many rising edges have passed since the edge that sampled the request. It expects the acknowledge after 5+N edges for a real move and after 2 edges for an equal request. On a falling move, the clock code should change at edge 2 and the voltage code at edge 3. On a rising move, the voltage code should change at edge 2 and the clock code at edge 4+N. Each recorded change edge is compared with these counts exactly. For held-off cases (tick low, regulator not ready), the codes and the acknowledge are sampled well past the normal deadline, then again within a few edges after the hold is released.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    ST_REST,
    ST_SLOW_CLK,
    ST_LOWER_V,
    ST_RAISE_V,
    ST_SETTLE,
    ST_FAST_CLK,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/vfs_level_clamp.sv
module vfs_level_clamp #(
  parameter int LEVEL_W   = 3,
  parameter int MIN_LEVEL = 2
) (
  input  logic [LEVEL_W-1:0] raw_level,
  output logic [LEVEL_W-1:0] safe_level
);
  localparam logic [LEVEL_W-1:0] FLOOR = LEVEL_W'(MIN_LEVEL);

  always_comb begin
    safe_level = (raw_level < FLOOR) ? FLOOR : raw_level;
  end

  always_comb begin
    a_r8_floor: assert (safe_level >= FLOOR);
  end
endmodule

// File: rtl/vfs_req_hold.sv
module vfs_req_hold #(
  parameter int LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LEVEL_W-1:0] in_level,
  input  logic               take,
  output logic               held_valid,
  output logic [LEVEL_W-1:0] held_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_level <= '0;
    end else if (in_valid) begin
      held_valid <= 1'b1;
      held_level <= in_level;
    end else if (take) begin
      held_valid <= 1'b0;
    end
  end

  // R7: a strobe is never lost, even when a held request is consumed the same cycle
  a_r7_strobe_held: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> held_valid);
endmodule

// File: rtl/vfs_settle_timer.sv
module vfs_settle_timer #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  input  logic                tick,
  output logic                expired
);
  logic [SETTLE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (tick && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

  // R4: no progress without a tick
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(remain));
endmodule

// File: rtl/vfs_sequencer.sv
module vfs_sequencer #(
  parameter int LEVEL_W   = 3,
  parameter int MIN_LEVEL = 2,
  parameter int SETTLE_W  = 16,
  parameter bit USE_READY = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [LEVEL_W-1:0]  req_level,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                reg_ready,
  input  logic                tick,
  output logic                req_ack,
  output logic [LEVEL_W-1:0]  volt_code,
  output logic [LEVEL_W-1:0]  clk_div
);
  import vfs_pkg::*;

  localparam logic [LEVEL_W-1:0] TOP = LEVEL_W'((1 << LEVEL_W) - 1);

  seq_state_e         state;
  logic [LEVEL_W-1:0] cur_lvl, tgt_lvl, safe_lvl, held_lvl;
  logic               rising, held_v, take, tmr_load, tmr_done, ready_ok;

  vfs_level_clamp #(.LEVEL_W(LEVEL_W), .MIN_LEVEL(MIN_LEVEL)) u_clamp (
    .raw_level (req_level),
    .safe_level(safe_lvl)
  );

  vfs_req_hold #(.LEVEL_W(LEVEL_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_level  (safe_lvl),
    .take      (take),
    .held_valid(held_v),
    .held_level(held_lvl)
  );

  vfs_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(settle_cycles),
    .tick    (tick),
    .expired (tmr_done)
  );

  generate
    if (USE_READY) begin : g_ready
      assign ready_ok = reg_ready;
    end else begin : g_no_ready
      assign ready_ok = 1'b1;
    end
  endgenerate

  assign take     = (state == ST_REST) && held_v;
  assign tmr_load = (state == ST_LOWER_V) || (state == ST_RAISE_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_REST;
      cur_lvl   <= TOP;
      tgt_lvl   <= TOP;
      rising    <= 1'b0;
      volt_code <= TOP;
      clk_div   <= '0;
      req_ack   <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      case (state)
        ST_REST: begin
          if (held_v) begin
            tgt_lvl <= held_lvl;
            if (held_lvl < cur_lvl) begin
              rising <= 1'b0;
              state  <= ST_SLOW_CLK;
            end else if (held_lvl > cur_lvl) begin
              rising <= 1'b1;
              state  <= ST_RAISE_V;
            end else begin
              state <= ST_FINISH;
            end
          end
        end
        ST_SLOW_CLK: begin
          clk_div <= TOP - tgt_lvl;
          state   <= ST_LOWER_V;
        end
        ST_LOWER_V, ST_RAISE_V: begin
          volt_code <= tgt_lvl;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_done && ready_ok) begin
            state <= rising ? ST_FAST_CLK : ST_FINISH;
          end
        end
        ST_FAST_CLK: begin
          clk_div <= TOP - tgt_lvl;
          state   <= ST_FINISH;
        end
        ST_FINISH: begin
          cur_lvl <= tgt_lvl;
          req_ack <= 1'b1;
          state   <= ST_REST;
        end
        default: state <= ST_REST;
      endcase
    end
  end

  // R9: supply always covers the clock speed
  a_r9_volt_covers_clk: assert property (@(posedge clk) disable iff (rst)
    volt_code >= (TOP - clk_div));

  // R2, R3: voltage only moves in the voltage-step states
  a_r3_volt_step_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(volt_code) |-> ($past(state) == ST_LOWER_V || $past(state) == ST_RAISE_V));

  // R2, R3: clock only moves in the clock-step states
  a_r2_clk_step_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_div) |-> ($past(state) == ST_SLOW_CLK || $past(state) == ST_FAST_CLK));

  // R10: acknowledge is one cycle wide
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R6: an equal request goes straight to finish without touching the codes
  a_r6_equal_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINISH && $past(state) == ST_REST) |-> ($stable(volt_code) && $stable(clk_div)));

  // R5: the settle state is never left while the regulator is not ready
  a_r5_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && USE_READY && !reg_ready) |=> (state == ST_SETTLE));
endmodule

// File: tb/vfs_sequencer_bench.sv
module vfs_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = 3'd0;
  logic [15:0] settle_cycles = 16'd0;
  logic        reg_ready = 1'b1;
  logic        tick = 1'b1;
  logic        req_ack;
  logic [2:0]  volt_code, clk_div;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vfs_sequencer u_vfs_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .settle_cycles(settle_cycles), .reg_ready(reg_ready), .tick(tick),
    .req_ack(req_ack), .volt_code(volt_code), .clk_div(clk_div)
  );

  // fields: level(3) settle(16) expected level(3) kind(2: 0 equal, 1 down, 2 up)
  localparam logic [23:0] VEC [0:5] = '{
    {3'd4, 16'd3,  3'd4, 2'd1},
    {3'd6, 16'd5,  3'd6, 2'd2},
    {3'd6, 16'd2,  3'd6, 2'd0},
    {3'd0, 16'd0,  3'd2, 2'd1},
    {3'd7, 16'd10, 3'd7, 2'd2},
    {3'd3, 16'd1,  3'd3, 2'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] lvl, input logic [15:0] n);
    @(negedge clk);
    settle_cycles = n;
    req_level = lvl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_req(input logic [2:0] lvl, input logic [15:0] n,
                         output int lat, output int tv, output int tc);
    logic [2:0] pv, pc;
    pv = volt_code;
    pc = clk_div;
    tv = -1; tc = -1; lat = -1;
    strobe(lvl, n);
    for (int k = 1; k < 300 && lat < 0; k++) begin
      @(negedge clk);
      if (volt_code != pv && tv < 0) tv = k;
      if (clk_div != pc && tc < 0) tc = k;
      if (req_ack) lat = k;
    end
  endtask

  task automatic wait_ack(input int limit, output int found);
    found = -1;
    for (int k = 1; k <= limit && found < 0; k++) begin
      @(negedge clk);
      if (req_ack) found = k;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, tv, tc, n, kind, exp_lvl, got;
    logic [2:0] lvl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(volt_code == 3'd7, "R1 volt", volt_code, 7);
    check(clk_div == 3'd0, "R1 div", clk_div, 0);
    check(req_ack == 1'b0, "R1 ack", req_ack, 0);

    // table walk: R2 R3 R6 R8
    for (int i = 0; i < 6; i++) begin
      lvl     = VEC[i][23:21];
      n       = int'(VEC[i][20:5]);
      exp_lvl = int'(VEC[i][4:2]);
      kind    = int'(VEC[i][1:0]);
      run_req(lvl, VEC[i][20:5], lat, tv, tc);
      check(volt_code == exp_lvl[2:0], "R2/R3/R8 volt", volt_code, exp_lvl);
      check(clk_div == 3'(7 - exp_lvl), "R9 div code", clk_div, 7 - exp_lvl);
      if (kind == 0) begin
        check(lat == 2, "R6 latency", lat, 2);
        check(tv < 0 && tc < 0, "R6 no change", tv + tc, -2);
      end else if (kind == 1) begin
        check(lat == 5 + n, "R2 latency", lat, 5 + n);
        check(tc == 2, "R2 clock edge", tc, 2);
        check(tv == 3, "R2 volt edge", tv, 3);
      end else begin
        check(lat == 5 + n, "R3 latency", lat, 5 + n);
        check(tv == 2, "R3 volt edge", tv, 2);
        check(tc == 4 + n, "R3 clock edge", tc, 4 + n);
      end
      @(negedge clk);
      check(req_ack == 1'b0, "R10 single pulse", req_ack, 0);
    end

    // R8: below-floor request while at floor behaves as equal
    run_req(3'd2, 16'd0, lat, tv, tc);
    run_req(3'd1, 16'd4, lat, tv, tc);
    check(lat == 2, "R8 clamp equal latency", lat, 2);
    check(volt_code == 3'd2, "R8 clamp volt", volt_code, 2);

    // R7: requests during a transition, latest wins
    strobe(3'd6, 16'd4);
    repeat (2) @(negedge clk);
    req_level = 3'd5; req_valid = 1'b1;
    @(negedge clk);
    req_level = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    wait_ack(40, got);
    check(got > 0, "R7 first ack", got, 1);
    check(volt_code == 3'd6 && clk_div == 3'd1, "R7 first point", volt_code, 6);
    wait_ack(40, got);
    check(got > 0, "R7 second ack", got, 1);
    check(volt_code == 3'd4 && clk_div == 3'd3, "R7 latest served", volt_code, 4);
    wait_ack(20, got);
    check(got < 0, "R7 no third ack", got, -1);

    // R5: regulator not ready holds the clock step
    reg_ready = 1'b0;
    strobe(3'd7, 16'd1);
    wait_ack(20, got);
    check(got < 0, "R5 no ack while not ready", got, -1);
    check(volt_code == 3'd7, "R5 volt raised", volt_code, 7);
    check(clk_div == 3'd3, "R5 clock held", clk_div, 3);
    reg_ready = 1'b1;
    wait_ack(6, got);
    check(got > 0, "R5 ack after ready", got, 1);
    check(clk_div == 3'd0, "R5 clock raised", clk_div, 0);

    // R4: settle count frozen without tick
    tick = 1'b0;
    strobe(3'd2, 16'd2);
    wait_ack(20, got);
    check(got < 0, "R4 no ack without tick", got, -1);
    check(volt_code == 3'd2 && clk_div == 3'd5, "R4 codes stepped", volt_code, 2);
    tick = 1'b1;
    wait_ack(6, got);
    check(got > 0, "R4 ack after ticks", got, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule